// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Master

This block is a single-lane serial peripheral master driven through a small 32-bit memory-mapped register port. Software sets up a frame in one command word: clock mode, which of four chip selects, frame length from 1 to 32 bits, bit and byte ordering, and whether the frame transmits, receives or both. Outgoing words go into a transmit word queue and captured words come back through a receive word queue. Each queue is reached through one fixed address. Writing the start bit together with the master bit runs exactly one frame. A ready flag marks the end of the frame.

Status is spread over two registers. A transfer status word holds the ready flag, which software clears by writing 1 to it. A queue status word holds live empty and full flags, four sticky error flags and a summary error bit. It also holds two flush bits that clear themselves. Chip select either follows the frame in hardware or is driven to a software-chosen level, so several frames can be chained under one select. The register port is a plain control port with no back-pressure: every access completes in the cycle it is presented. Read data is valid in that same cycle. A read of the receive address pops the queue at the closing clock edge.

Register offsets are 0x000 for the command, 0x010 for transfer status, 0x014 for queue status, 0x108 for the transmit queue write port and 0x188 for the receive queue read port. Reads of any other address return 0.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, all four chip selects are high, SCK and MOSI are 0, the command and transfer status registers read 0, and queue status reads 0x005 (both queues empty).
- R2: A command write with bit 31 (start) and bit 30 (master) both set, while no frame runs, starts a frame of len+1 bits, where len = bits 4:0. The frame has 2*(len+1) SCK edges. Command bit 31 reads 1 while the frame runs and 0 after it. A start without bit 30 runs no frame.
- R3: Command bits 29 and 28 are CPOL and CPHA. SCK idles at CPOL. With CPHA=0 MISO is sampled on the first, third, and later odd-numbered edges. With CPHA=1 it is sampled on the even-numbered edges. Every SCK half-period lasts CLK_DIV clock cycles.
- R4: Let T(w) reverse the byte order of w when command bit 15 is set, and reverse the bit order inside each byte when bit 16 is set. Bits N-1 down to 0 of T(tx word) are sent in that order. A received word is T(c), where c holds the first captured bit at position N-1.
- R5: Under hardware control (bit 21 = 0), the chip select chosen by bits 27:26 goes low one half-period before the first SCK edge and returns high one half-period after the last. The other selects stay inactive. Command bit 22 inverts CS0, so its inactive level becomes 0.
- R6: With bit 21 = 1, the chosen chip select drives the level in bit 20, and the others stay inactive.
- R7: Transfer status bit 30 is set when a frame completes. Writing 1 to it clears it.
- R8: A write to 0x108 pushes a word into the transmit queue. A start with bit 11 set pops one word. If the queue is empty at that start, zeros are sent and the TX-underrun flag (bit 6) is set. A write while the queue is full is dropped and sets the TX-overflow flag (bit 7).
- R9: A frame with bit 12 set pushes its received word at completion. If the receive queue is full, the word is dropped and the RX-overflow flag (bit 5) is set. A read of 0x188 pops the receive queue. A read while empty returns 0 and sets the RX-underrun flag (bit 4).
- R10: Queue status bits 0 to 3 are RX empty, RX full, TX empty and TX full. Bits 4 to 7 are sticky and are cleared by writing 1. Bit 8 is 1 whenever any of bits 4 to 7 is 1.
- R11: Writing 1 to queue status bit 14 empties the transmit queue, and writing 1 to bit 15 empties the receive queue. Each bit clears itself once its flush is done.
- R12: A command write while a frame runs is ignored entirely: the fields keep their values and the frame is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x188) |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Chip selects, active low |

## Verification
The bench builds the block with CLK_DIV = 2 and FIFO_DEPTH = 4. The short half-period lets it sweep every frame length from 1 to 32 bits against all four clock modes, cycling through the bit and byte orders and the chip selects along the way. It compares each transmitted and received word with values it computes itself from the ordering rule. The shallow queues make the full, overflow and underrun corners reachable in a few frames. The timing checks also measure the half-period chip-select lead and lag in clock cycles.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_CS  = 4;
  localparam int SEL_W   = 2;
  localparam int LEN_W   = 5;

  localparam int OFS_CMD = 32'h000;
  localparam int OFS_STS = 32'h010;
  localparam int OFS_FST = 32'h014;
  localparam int OFS_TXD = 32'h108;
  localparam int OFS_RXD = 32'h188;

  // Optional byte reversal, then optional bit reversal inside each byte.
  // Both steps undo themselves, so one function serves both directions.
  function automatic logic [WORD_W-1:0] order_word(input logic [WORD_W-1:0] w,
                                                   input logic bit_lsb,
                                                   input logic byte_rev);
    logic [WORD_W-1:0] t;
    logic [WORD_W-1:0] r;
    t = byte_rev ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    for (int i = 0; i < WORD_W; i++) begin
      r[i] = bit_lsb ? t[(i & ~7) + 7 - (i & 7)] : t[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_rm_fifo.sv
module spi_rm_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  len_m1,
  input  logic        cpol,
  input  logic        cpha,
  input  logic [31:0] tx_word,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic        sck,
  output logic        mosi,
  output logic [31:0] rx_word
);
  localparam int CNT_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int STEP_W = 7;

  logic              busy_q, cpha_q, sck_q;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] step, last_step;
  logic [31:0]       sh_tx, sh_rx;
  logic              wrap, at_end, lead, smp;

  assign wrap   = (cnt == CNT_W'(CLK_DIV - 1));
  assign at_end = (step == last_step);
  assign lead   = ~step[0];
  assign smp    = cpha_q ? ~lead : lead;
  assign done   = busy_q && wrap && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cpha_q    <= 1'b0;
      sck_q     <= 1'b0;
      cnt       <= '0;
      step      <= '0;
      last_step <= '0;
      sh_tx     <= '0;
      sh_rx     <= '0;
    end else if (!busy_q) begin
      sck_q <= cpol;
      if (start) begin
        busy_q    <= 1'b1;
        cnt       <= '0;
        step      <= '0;
        last_step <= ({2'b00, len_m1} + STEP_W'(1)) << 1;
        cpha_q    <= cpha;
        sh_tx     <= tx_word << (5'd31 - len_m1);
        sh_rx     <= '0;
      end
    end else if (wrap) begin
      cnt <= '0;
      if (at_end) begin
        busy_q <= 1'b0;
        sck_q  <= cpol;
      end else begin
        sck_q <= ~sck_q;
        step  <= step + STEP_W'(1);
        if (smp) sh_rx <= {sh_rx[30:0], miso};
        else if (step != '0) sh_tx <= {sh_tx[30:0], 1'b0};
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = busy_q & sh_tx[31];
  assign rx_word = sh_rx;
endmodule

// File: rtl/spi_rm_csel.sv
module spi_rm_csel #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              sw_mode,
  input  logic              sw_level,
  input  logic              cs0_inv,
  input  logic              frame_active,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    logic idle_lvl;
    assign idle_lvl = (g == 0) ? ~cs0_inv : 1'b1;
    assign cs_n[g]  = (sel != SEL_W'(g)) ? idle_lvl :
                      sw_mode            ? sw_level :
                      frame_active       ? ~idle_lvl : idle_lvl;
  end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_rm_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [3:0]        spi_cs_n
);
  logic hit_cmd, hit_sts, hit_fst, hit_txd, hit_rxd;
  logic wr_cmd, wr_sts, wr_fst, cmd_take, start;
  logic [30:0] cmd_q;
  logic        rdy_q, flush_tx_q, flush_rx_q;
  logic [3:0]  err_q, err_ev;
  logic        eng_busy, eng_done, cfg_cpol;
  logic [31:0] eng_tx, eng_rx, rx_in, tx_head, rx_head;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic        tx_push, tx_pop, rx_push, rx_pop, tx_en_now;

  assign hit_cmd = (reg_addr == ADDR_W'(OFS_CMD));
  assign hit_sts = (reg_addr == ADDR_W'(OFS_STS));
  assign hit_fst = (reg_addr == ADDR_W'(OFS_FST));
  assign hit_txd = (reg_addr == ADDR_W'(OFS_TXD));
  assign hit_rxd = (reg_addr == ADDR_W'(OFS_RXD));

  assign wr_cmd   = reg_wr && hit_cmd;
  assign wr_sts   = reg_wr && hit_sts;
  assign wr_fst   = reg_wr && hit_fst;
  assign cmd_take = wr_cmd && !eng_busy;
  assign start    = cmd_take && reg_wdata[31] && reg_wdata[30];
  assign cfg_cpol = cmd_take ? reg_wdata[29] : cmd_q[29];

  // transmit side: one word leaves the queue as the frame starts
  assign tx_en_now = reg_wdata[11];
  assign tx_push   = reg_wr && hit_txd;
  assign tx_pop    = start && tx_en_now && !tx_empty;
  assign eng_tx    = tx_pop ? order_word(tx_head, reg_wdata[16], reg_wdata[15]) : '0;

  // receive side: word enters the queue at completion
  assign rx_push = eng_done && cmd_q[12];
  assign rx_pop  = reg_rd && hit_rxd;
  assign rx_in   = order_word(eng_rx, cmd_q[16], cmd_q[15]);

  // sticky events: [0] rx underrun, [1] rx overflow, [2] tx underrun, [3] tx overflow
  assign err_ev = {tx_push && tx_full,
                   start && tx_en_now && tx_empty,
                   rx_push && rx_full,
                   rx_pop && rx_empty};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      rdy_q      <= 1'b0;
      err_q      <= '0;
      flush_tx_q <= 1'b0;
      flush_rx_q <= 1'b0;
    end else begin
      if (cmd_take) cmd_q <= reg_wdata[30:0];
      rdy_q      <= eng_done | (rdy_q & ~(wr_sts & reg_wdata[30]));
      err_q      <= (err_q & ~(wr_fst ? reg_wdata[7:4] : 4'b0000)) | err_ev;
      flush_tx_q <= wr_fst & reg_wdata[14];
      flush_rx_q <= wr_fst & reg_wdata[15];
    end
  end

  spi_rm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(reg_wdata), .pop(tx_pop),
    .flush(flush_tx_q), .head(tx_head), .full(tx_full), .empty(tx_empty));

  spi_rm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_in), .pop(rx_pop),
    .flush(flush_rx_q), .head(rx_head), .full(rx_full), .empty(rx_empty));

  spi_rm_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .len_m1(reg_wdata[4:0]),
    .cpol(cfg_cpol), .cpha(reg_wdata[28]), .tx_word(eng_tx), .miso(spi_miso),
    .busy(eng_busy), .done(eng_done), .sck(spi_sck), .mosi(spi_mosi), .rx_word(eng_rx));

  spi_rm_csel #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .sel(cmd_q[27:26]), .sw_mode(cmd_q[21]), .sw_level(cmd_q[20]),
    .cs0_inv(cmd_q[22]), .frame_active(eng_busy), .cs_n(spi_cs_n));

  always_comb begin
    reg_rdata = '0;
    if (hit_cmd)      reg_rdata = {eng_busy, cmd_q};
    else if (hit_sts) reg_rdata[30] = rdy_q;
    else if (hit_fst) reg_rdata = {16'b0, flush_rx_q, flush_tx_q, 5'b0, |err_q, err_q,
                                   tx_full, tx_empty, rx_full, rx_empty};
    else if (hit_rxd) reg_rdata = rx_empty ? '0 : rx_head;
  end
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sck,
  input logic [3:0]  cs_n,
  input logic        busy,
  input logic        cpol,
  input logic        sw_mode,
  input logic        cs0_inv,
  input logic        cmd_wr,
  input logic [30:0] cmd_val,
  input logic        flush_tx,
  input logic        tx_empty,
  input logic        rdy
);
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol)); // R3

  AST_HW_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_mode && !cs0_inv) |-> $onehot0(~cs_n)); // R5

  AST_HW_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sw_mode && !cs0_inv) |-> (cs_n != 4'hF)); // R5

  AST_RDY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rdy); // R7

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_val)); // R12

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx |=> tx_empty); // R11
endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .busy(eng_busy),
  .cpol(cmd_q[29]), .sw_mode(cmd_q[21]), .cs0_inv(cmd_q[22]), .cmd_wr(wr_cmd),
  .cmd_val(cmd_q), .flush_tx(flush_tx_q), .tx_empty(tx_empty), .rdy(rdy_q));

// File: tb/spi_reg_master_tb.sv
module spi_reg_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int DEPTH      = 4;
  localparam logic [8:0] A_CMD = 9'h000, A_STS = 9'h010, A_FST = 9'h014,
                         A_TXD = 9'h108, A_RXD = 9'h188;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, miso = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         sck, mosi;
  wire  [3:0]  cs_n;

  spi_reg_master #(.CLK_DIV(DIV), .FIFO_DEPTH(DEPTH), .ADDR_W(9)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] arrange(input logic [31:0] w, input bit lsb, input bit swap);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      int sb, sbit;
      sb   = swap ? 3 - i / 8 : i / 8;
      sbit = lsb ? 7 - i % 8 : i % 8;
      r[i] = w[sb * 8 + sbit];
    end
    return r;
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // bench-side serial device
  bit armed = 0, s_cpha = 0, cs_ok = 1, timing_ok = 1, cs_low = 0;
  int edges = 0, mi = 0, sel_now = 0, last_edge_cyc = 0, cs_fall_cyc = 0, cs_rise_cyc = 0;
  logic [31:0] s_word = '0, mcap = '0;

  always @(sck) if (armed) begin
    bit lead, smp;
    if (edges == 0 && cyc - cs_fall_cyc != DIV) timing_ok = 0;
    if (edges > 0 && cyc - last_edge_cyc != DIV) timing_ok = 0;
    last_edge_cyc = cyc;
    if (cs_n[sel_now] !== 1'b0) cs_ok = 0;
    lead = (edges % 2 == 0);
    smp  = s_cpha ? !lead : lead;
    if (smp) mcap = {mcap[30:0], mosi};
    else if (mi >= 0) begin miso = s_word[mi]; mi--; end
    edges++;
  end

  always @(cs_n) if (armed) begin
    if (cs_n[sel_now] === 1'b0 && !cs_low) begin cs_low = 1; cs_fall_cyc = cyc; end
    if (cs_n[sel_now] === 1'b1 && cs_low) begin cs_low = 0; cs_rise_cyc = cyc; end
  end

  task automatic frame(input int mode, input int len, input bit lsb, input bit swap,
                       input int sel, input logic [31:0] txw, input logic [31:0] sw,
                       input bit push_tx, input bit do_rx, input bit read_rx, input bit poke);
    logic [31:0] cfg, r, mask;
    int n;
    n    = len + 1;
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    cfg  = 32'h4000_0800 | (32'(mode) << 28) | (32'(sel) << 26) | (32'(lsb) << 16)
         | (32'(swap) << 15) | (32'(do_rx) << 12) | 32'(len);
    wr(A_CMD, cfg);
    if (push_tx) wr(A_TXD, txw);
    s_word = sw; s_cpha = mode[0]; sel_now = sel; mcap = '0; edges = 0;
    cs_ok = 1; timing_ok = 1; cs_low = 0;
    if (!s_cpha) begin miso = sw[n-1]; mi = n - 2; end else mi = n - 1;
    armed = 1;
    wr(A_CMD, cfg | 32'h8000_0000);
    if (poke) begin
      wr(A_CMD, 32'hC000_0000);
      rd(A_CMD, r);
      check("R2/R12 busy readback, write ignored", r, cfg | 32'h8000_0000);
    end
    for (int t = 0; t < 400; t++) begin
      rd(A_STS, r);
      if (r[30]) break;
    end
    armed = 0;
    check("R7 ready set", r, 32'h4000_0000);
    check("R2 edge count", 32'(edges), 32'(2 * n));
    check("R3 half-period timing", 32'(timing_ok), 1);
    check("R5 cs held low on edges", 32'(cs_ok), 1);
    check("R5 cs trailing half-period", 32'(cs_rise_cyc - last_edge_cyc), DIV);
    check("R4 mosi bit order", mcap & mask, push_tx ? (arrange(txw, lsb, swap) & mask) : 32'h0);
    if (do_rx && read_rx) begin
      rd(A_RXD, r);
      check("R9 R4 received word", r, arrange(sw & mask, lsb, swap));
    end
    rd(A_CMD, r);
    check("R2 start bit clear after frame", r[31], 1'b0);
    wr(A_STS, 32'h4000_0000);
    rd(A_STS, r);
    check("R7 ready cleared by write-one", r, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, first_rx;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 cs_n idle", 32'(cs_n), 32'hF);
    check("R1 sck idle", 32'(sck), 0);
    check("R1 mosi idle", 32'(mosi), 0);
    rd(A_CMD, r); check("R1 command reset", r, 0);
    rd(A_STS, r); check("R1 status reset", r, 0);
    rd(A_FST, r); check("R1 queue status reset", r, 32'h005);

    // R2 start without master bit does nothing
    wr(A_CMD, 32'h8000_0007);
    repeat (10) @(negedge clk);
    check("R2 no frame without master, cs", 32'(cs_n), 32'hF);
    rd(A_CMD, r); check("R2 no frame without master, cmd", r, 32'h0000_0007);
    rd(A_STS, r); check("R2 no frame without master, ready", r, 0);

    // R6 software chip select, R5 CS0 polarity
    wr(A_CMD, 32'h0820_0000);
    check("R6 sw level 0 on cs2", 32'(cs_n), 32'hB);
    wr(A_CMD, 32'h0830_0000);
    check("R6 sw level 1 on cs2", 32'(cs_n), 32'hF);
    wr(A_CMD, 32'h0440_0000);
    check("R5 cs0 inverted idle", 32'(cs_n), 32'hE);
    wr(A_CMD, 32'h0000_0000);

    // sweep: all lengths x all modes, orderings and selects cycling
    for (int len = 0; len < 32; len++) begin
      for (int mode = 0; mode < 4; mode++) begin
        int f;
        logic [31:0] tw;
        f  = (len + mode) % 4;
        tw = 32'h9E37_79B9 * 32'(len * 4 + mode + 1);
        frame(mode, len, f[0], f[1], mode, tw, ~tw ^ (32'(len) << 8), 1, 1, 1, 0);
      end
    end

    // R12 command write during a running frame
    frame(1, 31, 0, 0, 0, 32'hA5C3_0F96, 32'h1234_5678, 1, 1, 1, 1);

    // R8 transmit underrun: zeros sent, flag set
    frame(0, 7, 0, 0, 1, 32'h0, 32'h0, 0, 0, 0, 0);
    rd(A_FST, r); check("R8 R10 tx underrun flag", r, 32'h145);
    wr(A_FST, r);
    rd(A_FST, r); check("R10 write-back clears", r, 32'h005);

    // R8 transmit overflow, R11 flush
    for (int i = 0; i <= DEPTH; i++) wr(A_TXD, 32'(i));
    rd(A_FST, r); check("R8 R10 tx overflow and full", r, 32'h189);
    wr(A_FST, 32'h0000_4000);
    rd(A_FST, r); check("R11 tx flush self-clears, queue empty", r, 32'h185);
    wr(A_FST, 32'h0000_0080);
    rd(A_FST, r); check("R10 clear tx overflow", r, 32'h005);

    // R9 receive underrun
    rd(A_RXD, r); check("R9 empty read returns 0", r, 0);
    rd(A_FST, r); check("R9 R10 rx underrun flag", r, 32'h115);
    wr(A_FST, 32'h0000_0010);

    // R9 receive overflow
    for (int i = 0; i <= DEPTH; i++)
      frame(3, 0, 0, 0, 3, 32'h1, 32'(i + 1), 1, 1, 0, 0);
    rd(A_FST, r); check("R9 R10 rx overflow and full", r, 32'h126);
    rd(A_RXD, first_rx); check("R9 oldest word kept", first_rx, 32'h1);
    wr(A_FST, 32'h0000_8020);
    rd(A_FST, r); check("R11 rx flush self-clears, queue empty", r, 32'h005);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule